// File: doc/BRIEF.md
# Sensor Self-Test Sequencer

This block runs the built-in self-test of a two-axis sensor front end. A test is started either by software, through a self-clearing start bit in a control word, or automatically when reset is released. The automatic test is skipped when a persistent skip bit is set. A separate storage block supplies that bit's stored value at reset, and it reads back and can be rewritten through the same control word.

During a test the block drives a stimulus-enable output that deflects the sensing element. It waits for a settle interval of a fixed number of clock cycles. On the final cycle it checks every axis sample against an inclusive pair of limits supplied as inputs. Any sample outside the limits sets a fail bit in the status word. The fail bit holds until the next test starts. New-data indications from the conversion path are blocked for the whole test window.

Top module: `selftest_seq`

## Requirements
- R1: When reset is released with `boot_skip_cfg` = 0, a test is already running: control bit 8 reads 1 and `stim_en` is 1, and the test lasts `SETTLE_CYC` cycles.
- R2: When reset is released with `boot_skip_cfg` = 1, no test runs, and control bit 10 reads 1.
- R3: While the block is idle, a control write with bit 8 set starts a test. Control bit 8 and `stim_en` read 1 from the clock edge that takes the write.
- R4: Control bit 8 and `stim_en` stay 1 for exactly `SETTLE_CYC` cycles and then return to 0 with no further write.
- R5: At the end of a test, status bit 5 becomes 1 if any axis sample in the final cycle of the window is below `lim_lo` or above `lim_hi`. Otherwise it becomes 0. Samples equal to a limit pass, and sample values earlier in the window have no effect.
- R6: Status bit 5 keeps its value until the next test starts, and it is cleared on the edge that starts that test.
- R7: A control write with bit 8 set while a test is running is ignored: the running test neither restarts nor lengthens.
- R8: `data_new_out` equals `data_new_in` while the block is idle and is 0 while a test is running.
- R9: Every control write loads bit 10 into the persistent skip bit, which reads back on control bit 10. A write with bit 8 clear starts no test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_skip_cfg | input | 1 | Stored skip-bit value, loaded at reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control write data (bit 8 start, bit 10 skip) |
| ctl_rdata | output | 16 | Control readback (bit 8 busy, bit 10 skip) |
| sts_rdata | output | 16 | Status word (bit 5 fail) |
| axis_smp | input | NAXES*W | Signed axis samples packed, axis 0 in the low bits |
| lim_lo | input | W | Signed lower pass limit, inclusive |
| lim_hi | input | W | Signed upper pass limit, inclusive |
| stim_en | output | 1 | Stimulus enable to the sensing element |
| data_new_in | input | 1 | New-data indication from the conversion path |
| data_new_out | output | 1 | Gated new-data indication |

## Verification
The hardest case to reach is a verdict that depends only on the last cycle of the window. It takes samples that are out of range early in the test and back in range when the test ends. The bench changes `axis_smp` partway through a test, and it also does the reverse, so that only the final sample fails. A second hard case is a start request that arrives inside a running test. The bench issues it a few cycles after a start and counts the busy cycles to show that the window length does not change.

// File: rtl/selftest_pkg.sv
package selftest_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } st_e;

    localparam int CTL_START_BIT = 8;
    localparam int CTL_SKIP_BIT  = 10;
    localparam int STS_FAIL_BIT  = 5;

    typedef struct packed {
        logic [4:0] rsv_hi;
        logic       skip;
        logic       rsv_mid;
        logic       start;
        logic [7:0] rsv_lo;
    } ctl_word_t;

    typedef struct packed {
        logic [9:0] rsv_hi;
        logic       fail;
        logic [4:0] rsv_lo;
    } sts_word_t;

    function automatic logic outside_window(input logic signed [31:0] v,
                                            input logic signed [31:0] lo,
                                            input logic signed [31:0] hi);
        return (v < lo) || (v > hi);
    endfunction

endpackage

// File: rtl/st_settle_timer.sv
module st_settle_timer #(
    parameter int SETTLE_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = run && (cnt_q == LAST);
endmodule

// File: rtl/st_limit_check.sv
module st_limit_check
    import selftest_pkg::*;
#(
    parameter int W     = 16,
    parameter int NAXES = 2
) (
    input  logic [NAXES*W-1:0] smp,
    input  logic [W-1:0]       lo,
    input  logic [W-1:0]       hi,
    output logic               any_out
);
    logic [NAXES-1:0] oor;
    logic signed [31:0] lo_x, hi_x;

    assign lo_x = 32'(signed'(lo));
    assign hi_x = 32'(signed'(hi));

    for (genvar a = 0; a < NAXES; a++) begin : g_axis
        logic signed [31:0] v_x;
        assign v_x    = 32'(signed'(smp[a*W +: W]));
        assign oor[a] = outside_window(v_x, lo_x, hi_x);
    end

    assign any_out = |oor;
endmodule

// File: rtl/selftest_seq.sv
module selftest_seq
    import selftest_pkg::*;
#(
    parameter int W          = 16,
    parameter int NAXES      = 2,
    parameter int CLK_MHZ    = 125,
    parameter int SETTLE_US  = 35000,
    parameter int SETTLE_CYC = CLK_MHZ * SETTLE_US
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               boot_skip_cfg,
    input  logic               ctl_wr,
    input  logic [15:0]        ctl_wdata,
    output logic [15:0]        ctl_rdata,
    output logic [15:0]        sts_rdata,
    input  logic [NAXES*W-1:0] axis_smp,
    input  logic [W-1:0]       lim_lo,
    input  logic [W-1:0]       lim_hi,
    output logic               stim_en,
    input  logic               data_new_in,
    output logic               data_new_out
);
    st_e       st_q;
    logic      skip_q;
    logic      fail_q;
    logic      done;
    logic      any_out;
    logic      start;
    ctl_word_t wr_w;
    ctl_word_t rd_w;
    sts_word_t st_w;

    assign wr_w  = ctl_word_t'(ctl_wdata);
    assign start = ctl_wr && wr_w.start && (st_q == ST_IDLE);

    st_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) tmr_i (
        .clk (clk),
        .rst (rst),
        .run (st_q == ST_RUN),
        .done(done)
    );

    st_limit_check #(.W(W), .NAXES(NAXES)) lim_i (
        .smp    (axis_smp),
        .lo     (lim_lo),
        .hi     (lim_hi),
        .any_out(any_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= boot_skip_cfg ? ST_IDLE : ST_RUN;
            skip_q <= boot_skip_cfg;
            fail_q <= 1'b0;
        end else begin
            if (ctl_wr) begin
                skip_q <= wr_w.skip;
            end
            unique case (st_q)
                ST_IDLE: if (start) begin
                    st_q   <= ST_RUN;
                    fail_q <= 1'b0;
                end
                ST_RUN: if (done) begin
                    st_q   <= ST_IDLE;
                    fail_q <= any_out;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        rd_w       = '0;
        rd_w.start = (st_q == ST_RUN);
        rd_w.skip  = skip_q;
        st_w       = '0;
        st_w.fail  = fail_q;
    end

    assign ctl_rdata    = rd_w;
    assign sts_rdata    = st_w;
    assign stim_en      = (st_q == ST_RUN);
    assign data_new_out = data_new_in && (st_q == ST_IDLE);
endmodule

// File: rtl/selftest_seq_chk.sv
module selftest_seq_chk #(
    parameter int SETTLE_CYC = 16
) (
    input logic        clk,
    input logic        rst,
    input logic        ctl_wr,
    input logic [15:0] ctl_wdata,
    input logic [15:0] ctl_rdata,
    input logic [15:0] sts_rdata,
    input logic        stim_en,
    input logic        data_new_out
);
    logic        busy;
    logic        fail;
    logic [31:0] run_cnt;

    assign busy = ctl_rdata[8];
    assign fail = sts_rdata[5];

    always_ff @(posedge clk) begin
        if (rst || !busy) run_cnt <= '0;
        else              run_cnt <= run_cnt + 1;
    end

    // R4
    window_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_cnt == 32'(SETTLE_CYC)));

    // R8
    gate_new_chk: assert property (@(posedge clk) disable iff (rst)
        stim_en |-> !data_new_out);

    // R3
    start_take_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && ctl_wr && ctl_wdata[8]) |=> (busy && stim_en));

    // R6
    fail_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !fail);

    // R6
    fail_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy)) |-> $stable(fail));
endmodule

bind selftest_seq selftest_seq_chk #(.SETTLE_CYC(SETTLE_CYC)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .ctl_wr      (ctl_wr),
    .ctl_wdata   (ctl_wdata),
    .ctl_rdata   (ctl_rdata),
    .sts_rdata   (sts_rdata),
    .stim_en     (stim_en),
    .data_new_out(data_new_out)
);

// File: tb/selftest_seq_tb_top.sv
module selftest_seq_tb_top;
    localparam int W = 16;
    localparam int NAXES = 2;
    localparam int SETTLE = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              boot_skip_cfg = 1'b0;
    logic              ctl_wr = 1'b0;
    logic [15:0]       ctl_wdata = '0;
    logic [15:0]       ctl_rdata;
    logic [15:0]       sts_rdata;
    logic [2*W-1:0]    axis_smp = '0;
    logic [W-1:0]      lim_lo = W'(-100);
    logic [W-1:0]      lim_hi = W'(100);
    logic              stim_en;
    logic              data_new_in = 1'b1;
    logic              data_new_out;

    int n_chk = 0;
    int n_bad = 0;
    int wd    = 0;

    always #4 clk = ~clk;

    selftest_seq #(.W(W), .NAXES(NAXES), .SETTLE_CYC(SETTLE)) dut_i (
        .clk(clk), .rst(rst), .boot_skip_cfg(boot_skip_cfg),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .sts_rdata(sts_rdata), .axis_smp(axis_smp), .lim_lo(lim_lo),
        .lim_hi(lim_hi), .stim_en(stim_en), .data_new_in(data_new_in),
        .data_new_out(data_new_out)
    );

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd == 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_axes(input int x, input int y);
        axis_smp = {W'(y), W'(x)};
    endtask

    task automatic do_reset(input bit skip);
        boot_skip_cfg = skip;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [15:0] d);
        ctl_wr = 1'b1; ctl_wdata = d;
        @(negedge clk);
        ctl_wr = 1'b0; ctl_wdata = '0;
    endtask

    // Count negedges with busy high, starting at the current negedge.
    task automatic count_busy(output int n);
        n = 0;
        while (ctl_rdata[8] && n < 4*SETTLE) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_boot_run();
        int n;
        set_axes(10, -10);
        do_reset(1'b0);
        chk(ctl_rdata[8] == 1'b1, "R1 busy after reset", ctl_rdata[8], 1);
        chk(stim_en == 1'b1, "R1 stim_en after reset", stim_en, 1);
        chk(data_new_out == 1'b0, "R8 gated in boot test", data_new_out, 0);
        count_busy(n);
        chk(n == SETTLE, "R1 boot window length", n, SETTLE);
        chk(sts_rdata[5] == 1'b0, "R5 boot pass", sts_rdata[5], 0);
        chk(data_new_out == 1'b1, "R8 pass-through idle", data_new_out, 1);
        data_new_in = 1'b0;
        #1;
        chk(data_new_out == 1'b0, "R8 pass-through low", data_new_out, 0);
        data_new_in = 1'b1;
    endtask

    task automatic t_boot_skip();
        do_reset(1'b1);
        repeat (3) @(negedge clk);
        chk(ctl_rdata[8] == 1'b0, "R2 no boot test", ctl_rdata[8], 0);
        chk(stim_en == 1'b0, "R2 stim_en low", stim_en, 0);
        chk(ctl_rdata[10] == 1'b1, "R2 skip readback", ctl_rdata[10], 1);
    endtask

    task automatic t_cmd_run(input int x, input int y, input bit exp_fail, input string tag);
        int n;
        set_axes(x, y);
        wr(16'h0100);
        chk(ctl_rdata[8] == 1'b1, "R3 start taken", ctl_rdata[8], 1);
        chk(stim_en == 1'b1, "R3 stim_en up", stim_en, 1);
        chk(sts_rdata[5] == 1'b0, "R6 fail cleared at start", sts_rdata[5], 0);
        count_busy(n);
        chk(n == SETTLE, "R4 window length", n, SETTLE);
        chk(stim_en == 1'b0, "R4 stim_en down", stim_en, 0);
        chk(sts_rdata[5] == exp_fail, tag, sts_rdata[5], exp_fail);
        repeat (5) @(negedge clk);
        chk(sts_rdata[5] == exp_fail, "R6 fail held", sts_rdata[5], exp_fail);
    endtask

    task automatic t_late_sample(input bit bad_first);
        int n;
        if (bad_first) set_axes(500, 0); else set_axes(0, 0);
        wr(16'h0100);
        repeat (SETTLE/2) @(negedge clk);
        if (bad_first) set_axes(0, 0); else set_axes(0, -101);
        count_busy(n);
        chk(sts_rdata[5] == !bad_first, "R5 only last sample counts", sts_rdata[5], !bad_first);
    endtask

    task automatic t_restart_ignored();
        int n;
        set_axes(0, 0);
        wr(16'h0100);
        repeat (4) @(negedge clk);
        wr(16'h0100);
        count_busy(n);
        chk(n == SETTLE - 5, "R7 restart ignored", n, SETTLE - 5);
    endtask

    task automatic t_skip_write();
        wr(16'h0400);
        chk(ctl_rdata[10] == 1'b1, "R9 skip set", ctl_rdata[10], 1);
        chk(ctl_rdata[8] == 1'b0, "R9 no start", ctl_rdata[8], 0);
        wr(16'h0000);
        chk(ctl_rdata[10] == 1'b0, "R9 skip cleared", ctl_rdata[10], 0);
    endtask

    initial begin
        @(negedge clk);
        t_boot_run();
        t_boot_skip();
        t_cmd_run(100, -100, 1'b0, "R5 limits inclusive pass");
        t_cmd_run(101, 0, 1'b1, "R5 x above hi fails");
        t_cmd_run(0, -101, 1'b1, "R5 y below lo fails");
        t_cmd_run(-5, 7, 1'b0, "R5 mid-range pass");
        t_late_sample(1'b1);
        t_late_sample(1'b0);
        t_restart_ignored();
        t_skip_write();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule